// File: doc/BRIEF.md
# LUT-Driven PWM Pattern Sequencer

This block drives a single pulse-width modulated output for LED dimming and indicator light patterns. The duty value comes from one of two sources. In fixed mode it is a programmed 9-bit register. In pattern mode a sequencer walks a bounded window of a small duty look-up table. The walk can ramp up, ramp down, restart as a sawtooth, or bounce as a triangle. It can pause at either end and either repeat or stop on its final value.

A host loads the table and all settings through a simple byte-wide write port. A one-cycle millisecond tick paces every step and pause. The block reports the table index currently in use and a flag that marks a finished, non-repeating pattern. The PWM waveform comes from a free-running 9-bit counter. A new duty value is taken only when a counter period ends.

Top module: `lut_pwm_seq`

## Requirements
- R1: Duty values are 9 bits. Table entry k is written as two bytes. Byte address 0x80+2k holds bits 7..0, and bit 0 of byte address 0x81+2k holds bit 8. The fixed duty is written the same way: bits 7..0 at address 0x01 and bit 8 in bit 0 of address 0x02.
- R2: A write of a value at or above the table size to the low-index register (0x03) or the high-index register (0x04) is ignored and the old value is kept. If pattern mode starts with the low index above the high index, the start is refused: the output stays low and the done flag stays clear until the block is disabled.
- R3: Each table index is held for the step length in ticks, taken from register 0x05; a value of 0 acts as 1. The index never changes in a cycle without a tick, except when a pattern starts.
- R4: Control bit 2 selects the direction. A value of 1 starts at the low index and moves upward. A value of 0 starts at the high index and moves downward.
- R5: When a pass reaches the end it is moving toward, a pause follows if that end's pause is enabled and its length is non-zero. Control bit 5 enables the pause at the high end, with its length in register 0x06. Control bit 6 enables the pause at the low end, with its length in register 0x07. The index stays on the end value for the pause length in ticks.
- R6: After a pass completes, with control bit 3 set the walk reverses and steps one index away from the end it reached, giving a triangle. With bit 3 clear, it jumps back to the starting end, giving a sawtooth.
- R7: With control bit 4 (repeat) clear, the walk stops after the final pass and its pause. It holds the last index and duty and raises done, and stays in that state until the block is disabled and enabled again.
- R8: Control bit 1 selects the mode: 0 is fixed duty and 1 is pattern mode. Only the selected source drives the output. Control bit 0 is the enable.
- R9: When enabled, the output is high for exactly D clock cycles out of every 512, where D is the applied duty (0 to 511).
- R10: A new duty value takes effect only at a 512-cycle period boundary, so each period contains exactly one high pulse for any duty from 1 to 511.
- R11: Clearing the enable drives the output low within two cycles. It also clears done and returns the sequencer to idle, so the next enable restarts the pattern from its starting end.
- R12: While a valid pattern runs, the reported index stays within the low to high window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond pacing strobe |
| wr_en | input | 1 | Register or table write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| pwm_o | output | 1 | Registered PWM output |
| lut_idx_o | output | IDX_W | Table index currently used by the sequencer |
| done_o | output | 1 | Non-repeating pattern has finished |

## Verification
The in-line assertions check several properties on every cycle. They confirm that out-of-range index writes leave the registers unchanged and that the index never moves without a tick outside a start. They confirm that a finished pattern holds both index and done while it stays enabled, that the applied duty changes only at the counter wrap, and that a dropped enable silences the output on the next cycle. Some behaviour can only be shown by the bench scenarios. These are the exact sequence of indices produced by each combination of direction, toggle, repeat and pause settings, and the high time per period for the fixed and table duties. They also include the single-pulse-per-period behaviour when the duty rises mid-period, and the restart from the starting end after a re-enable.

// File: rtl/lpgs_pkg.sv
package lpgs_pkg;
  localparam int DUTY_W = 9;
  localparam int TIME_W = 8;

  localparam int REG_CTRL     = 0;
  localparam int REG_FIX_LO   = 1;
  localparam int REG_FIX_HI   = 2;
  localparam int REG_LO_IDX   = 3;
  localparam int REG_HI_IDX   = 4;
  localparam int REG_STEP     = 5;
  localparam int REG_PAUSE_HI = 6;
  localparam int REG_PAUSE_LO = 7;

  // control byte, bit 0 is the enable
  typedef struct packed {
    logic pause_lo_en;
    logic pause_hi_en;
    logic repeat_en;
    logic toggle;
    logic walk_up;
    logic lut_mode;
    logic enable;
  } ctrl_t;

  typedef enum logic [2:0] {
    W_IDLE,
    W_STEP,
    W_PAUSE,
    W_DONE,
    W_REJECT
  } walk_state_t;
endpackage

// File: rtl/lpgs_regs.sv
module lpgs_regs
  import lpgs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output ctrl_t               ctrl_q,
  output logic [DUTY_W-1:0]   fixed_duty_q,
  output logic [IDX_W-1:0]    lo_idx_q,
  output logic [IDX_W-1:0]    hi_idx_q,
  output logic [TIME_W-1:0]   step_len_q,
  output logic [TIME_W-1:0]   pause_hi_q,
  output logic [TIME_W-1:0]   pause_lo_q,
  output logic                lut_we,
  output logic [IDX_W-1:0]    lut_waddr,
  output logic                lut_wsel_msb,
  output logic [7:0]          lut_wdata
);
  // table bytes live in the upper half of the address space; the bits
  // between the table offset and the top bit must be zero
  logic in_table;
  logic idx_ok;
  logic reg_space;

  assign in_table  = wr_addr[ADDR_W-1] && (wr_addr[ADDR_W-2:IDX_W+1] == '0);
  assign reg_space = !wr_addr[ADDR_W-1];
  assign idx_ok    = (wr_data[7:IDX_W] == '0);

  assign lut_we       = wr_en && in_table;
  assign lut_waddr    = wr_addr[IDX_W:1];
  assign lut_wsel_msb = wr_addr[0];
  assign lut_wdata    = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q       <= '0;
      fixed_duty_q <= '0;
      lo_idx_q     <= '0;
      hi_idx_q     <= '0;
      step_len_q   <= TIME_W'(1);
      pause_hi_q   <= '0;
      pause_lo_q   <= '0;
    end else if (wr_en && reg_space) begin
      case (int'(wr_addr))
        REG_CTRL:     ctrl_q <= ctrl_t'(wr_data[6:0]);
        REG_FIX_LO:   fixed_duty_q[7:0] <= wr_data;
        REG_FIX_HI:   fixed_duty_q[8] <= wr_data[0];
        REG_LO_IDX:   if (idx_ok) lo_idx_q <= wr_data[IDX_W-1:0];
        REG_HI_IDX:   if (idx_ok) hi_idx_q <= wr_data[IDX_W-1:0];
        REG_STEP:     step_len_q <= wr_data;
        REG_PAUSE_HI: pause_hi_q <= wr_data;
        REG_PAUSE_LO: pause_lo_q <= wr_data;
        default: ;
      endcase
    end
  end

  assert_lo_reject_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) == REG_LO_IDX && wr_data[7:IDX_W] != '0) |=> $stable(lo_idx_q));
  assert_hi_reject_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) == REG_HI_IDX && wr_data[7:IDX_W] != '0) |=> $stable(hi_idx_q));
endmodule

// File: rtl/lpgs_lut_mem.sv
module lpgs_lut_mem
  import lpgs_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic               wsel_msb,
  input  logic [7:0]         wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [DUTY_W-1:0]  rdata
);
  localparam int ENTRIES = 1 << IDX_W;

  // split by byte lane so each array maps to a simple dual-port RAM
  logic [7:0] low_mem [ENTRIES];
  logic       msb_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we && !wsel_msb) low_mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && wsel_msb) msb_mem[waddr] <= wdata[0];
  end

  always_ff @(posedge clk) begin
    rdata <= {msb_mem[raddr], low_mem[raddr]};
  end
endmodule

// File: rtl/lpgs_walker.sv
module lpgs_walker
  import lpgs_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               run,
  input  ctrl_t              ctrl,
  input  logic [IDX_W-1:0]   lo_idx,
  input  logic [IDX_W-1:0]   hi_idx,
  input  logic [TIME_W-1:0]  step_len,
  input  logic [TIME_W-1:0]  pause_hi,
  input  logic [TIME_W-1:0]  pause_lo,
  output logic [IDX_W-1:0]   idx_q,
  output logic               done_q,
  output logic               active
);
  walk_state_t       state_q;
  logic              up_q;
  logic [TIME_W-1:0] hold_q;
  logic [TIME_W-1:0] pcnt_q;

  logic              at_end;
  logic              step_hit;
  logic              pause_hit;
  logic              end_pause;
  logic [TIME_W-1:0] end_len;
  walk_state_t       fin_state;
  logic [IDX_W-1:0]  fin_idx;
  logic              fin_up;
  logic [IDX_W-1:0]  start_idx;

  assign start_idx = ctrl.walk_up ? lo_idx : hi_idx;
  assign at_end    = up_q ? (idx_q >= hi_idx) : (idx_q <= lo_idx);
  assign end_len   = up_q ? pause_hi : pause_lo;
  assign end_pause = (up_q ? ctrl.pause_hi_en : ctrl.pause_lo_en) && (end_len != '0);
  assign step_hit  = ({1'b0, hold_q} + (TIME_W+1)'(1)) >= {1'b0, step_len};
  assign pause_hit = ({1'b0, pcnt_q} + (TIME_W+1)'(1)) >= {1'b0, end_len};
  assign active    = run && (state_q inside {W_STEP, W_PAUSE, W_DONE});

  // what happens once a pass and its end pause are complete
  always_comb begin
    fin_state = W_STEP;
    fin_idx   = idx_q;
    fin_up    = up_q;
    if (!ctrl.repeat_en) begin
      fin_state = W_DONE;
    end else if (ctrl.toggle) begin
      fin_up = !up_q;
      if (lo_idx != hi_idx) fin_idx = up_q ? idx_q - IDX_W'(1) : idx_q + IDX_W'(1);
    end else begin
      fin_up  = ctrl.walk_up;
      fin_idx = start_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= W_IDLE;
      idx_q   <= '0;
      up_q    <= 1'b1;
      hold_q  <= '0;
      pcnt_q  <= '0;
      done_q  <= 1'b0;
    end else if (!run) begin
      state_q <= W_IDLE;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        W_IDLE: begin
          done_q <= 1'b0;
          hold_q <= '0;
          if (lo_idx > hi_idx) begin
            state_q <= W_REJECT;
          end else begin
            state_q <= W_STEP;
            idx_q   <= start_idx;
            up_q    <= ctrl.walk_up;
          end
        end
        W_STEP: begin
          if (tick) begin
            if (!step_hit) begin
              hold_q <= hold_q + TIME_W'(1);
            end else begin
              hold_q <= '0;
              if (!at_end) begin
                idx_q <= up_q ? idx_q + IDX_W'(1) : idx_q - IDX_W'(1);
              end else if (end_pause) begin
                state_q <= W_PAUSE;
                pcnt_q  <= '0;
              end else begin
                state_q <= fin_state;
                idx_q   <= fin_idx;
                up_q    <= fin_up;
                done_q  <= (fin_state == W_DONE);
              end
            end
          end
        end
        W_PAUSE: begin
          if (tick) begin
            if (!pause_hit) begin
              pcnt_q <= pcnt_q + TIME_W'(1);
            end else begin
              state_q <= fin_state;
              idx_q   <= fin_idx;
              up_q    <= fin_up;
              done_q  <= (fin_state == W_DONE);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_no_move_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q != W_IDLE && !tick) |=> $stable(idx_q));
  assert_done_holds_index_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> $stable(idx_q));
  assert_done_sticks_R7: assert property (@(posedge clk) disable iff (rst)
    (done_q && run) |=> done_q);
  assert_mode_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!done_q && !active));
endmodule

// File: rtl/lpgs_pwm_core.sv
module lpgs_pwm_core
  import lpgs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DUTY_W-1:0]  duty_next,
  output logic               pwm_q
);
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] duty_act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      duty_act_q <= '0;
      pwm_q      <= 1'b0;
    end else begin
      cnt_q <= cnt_q + DUTY_W'(1);
      if (cnt_q == '1) duty_act_q <= duty_next;
      pwm_q <= en && (cnt_q < duty_act_q);
    end
  end

  assert_duty_at_boundary_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $stable(duty_act_q));
endmodule

// File: rtl/lut_pwm_seq.sv
module lut_pwm_seq
  import lpgs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              pwm_o,
  output logic [IDX_W-1:0]  lut_idx_o,
  output logic              done_o
);
  ctrl_t              ctrl;
  logic [DUTY_W-1:0]  fixed_duty;
  logic [IDX_W-1:0]   lo_idx;
  logic [IDX_W-1:0]   hi_idx;
  logic [TIME_W-1:0]  step_len;
  logic [TIME_W-1:0]  pause_hi;
  logic [TIME_W-1:0]  pause_lo;
  logic               lut_we;
  logic [IDX_W-1:0]   lut_waddr;
  logic               lut_wsel_msb;
  logic [7:0]         lut_wdata;
  logic [DUTY_W-1:0]  lut_duty;
  logic               run;
  logic               seq_active;
  logic               pwm_en;
  logic [DUTY_W-1:0]  duty_sel;

  lpgs_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl), .fixed_duty_q(fixed_duty), .lo_idx_q(lo_idx), .hi_idx_q(hi_idx),
    .step_len_q(step_len), .pause_hi_q(pause_hi), .pause_lo_q(pause_lo),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wsel_msb(lut_wsel_msb),
    .lut_wdata(lut_wdata)
  );

  lpgs_lut_mem #(.IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(lut_we), .waddr(lut_waddr), .wsel_msb(lut_wsel_msb),
    .wdata(lut_wdata), .raddr(lut_idx_o), .rdata(lut_duty)
  );

  assign run = ctrl.enable && ctrl.lut_mode;

  lpgs_walker #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst(rst), .tick(tick_ms), .run(run), .ctrl(ctrl),
    .lo_idx(lo_idx), .hi_idx(hi_idx), .step_len(step_len),
    .pause_hi(pause_hi), .pause_lo(pause_lo),
    .idx_q(lut_idx_o), .done_q(done_o), .active(seq_active)
  );

  assign pwm_en   = ctrl.enable && (!ctrl.lut_mode || seq_active);
  assign duty_sel = ctrl.lut_mode ? lut_duty : fixed_duty;

  lpgs_pwm_core u_pwm (
    .clk(clk), .rst(rst), .en(pwm_en), .duty_next(duty_sel), .pwm_q(pwm_o)
  );

  assert_off_low_R11: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !pwm_o);
endmodule

// File: tb/sim_lut_pwm_seq.sv
`timescale 1ns/1ps
module sim_lut_pwm_seq;
  localparam int IDX_W = 5;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pwm;
  logic [IDX_W-1:0] idx;
  logic done;

  always #10 clk = ~clk;

  lut_pwm_seq u0 (
    .clk(clk), .rst(rst), .tick_ms(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm), .lut_idx_o(idx), .done_o(done)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  int exp_lut[ENTRIES];

  // configuration and reference model state
  int c_lo, c_hi, c_step, c_phl, c_pll, c_up, c_tog, c_rep, c_phe, c_ple;
  int m_idx, m_up, m_hold, m_pc, m_state;  // state: 1 step, 2 pause, 3 done

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[7:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic set_fixed(input int d);
    wr(1, d & 255);
    wr(2, d >> 8);
  endtask

  function automatic int ctrl_word(input int en, input int lut);
    return en | (lut << 1) | (c_up << 2) | (c_tog << 3) | (c_rep << 4) |
           (c_phe << 5) | (c_ple << 6);
  endfunction

  task automatic load_cfg();
    wr(0, 0);
    wr(3, c_lo); wr(4, c_hi); wr(5, c_step); wr(6, c_phl); wr(7, c_pll);
  endtask

  task automatic m_start();
    m_idx = c_up ? c_lo : c_hi;
    m_up = c_up; m_hold = 0; m_pc = 0; m_state = 1;
  endtask

  task automatic m_finish();
    if (c_rep == 0) m_state = 3;
    else if (c_tog != 0) begin
      if (c_lo != c_hi) m_idx = m_up ? m_idx - 1 : m_idx + 1;
      m_up = 1 - m_up; m_state = 1;
    end else begin
      m_idx = c_up ? c_lo : c_hi; m_up = c_up; m_state = 1;
    end
  endtask

  task automatic m_tick();
    int plen;
    int pen;
    plen = m_up ? c_phl : c_pll;
    pen = m_up ? c_phe : c_ple;
    if (m_state == 1) begin
      if (m_hold + 1 >= c_step) begin
        m_hold = 0;
        if (m_up ? (m_idx < c_hi) : (m_idx > c_lo)) m_idx = m_up ? m_idx + 1 : m_idx - 1;
        else if (pen != 0 && plen != 0) begin m_state = 2; m_pc = 0; end
        else m_finish();
      end else m_hold++;
    end else if (m_state == 2) begin
      if (m_pc + 1 >= plen) m_finish();
      else m_pc++;
    end
  endtask

  // run the loaded pattern for n ticks, comparing index and done each tick
  task automatic run_pattern(input int n, input string tag);
    wr(0, ctrl_word(1, 1));
    wait_cyc(2);
    m_start();
    check({tag, " R4 start index"}, int'(idx), m_idx);
    for (int t = 0; t < n; t++) begin
      tick1();
      m_tick();
      check({tag, " R3/R5/R6 index R12"}, int'(idx), m_idx);
      check({tag, " R7 done"}, int'(done), (m_state == 3) ? 1 : 0);
    end
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hi;
    int rises;
    int prev;
    void'($urandom(32'd7321));
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset pwm", int'(pwm), 0);
    check("R11 reset done", int'(done), 0);
    check("R11 reset index", int'(idx), 0);

    for (int k = 0; k < ENTRIES; k++) begin
      exp_lut[k] = int'($urandom % 512);
      wr(8'h80 + 2 * k, exp_lut[k] & 255);
      wr(8'h81 + 2 * k, exp_lut[k] >> 8);
    end

    // fixed mode duties, including both extremes
    c_up = 0; c_tog = 0; c_rep = 0; c_phe = 0; c_ple = 0;
    foreach (exp_lut[k]) ;
    begin
      int duties[4] = '{0, 511, 300, 77};
      for (int j = 0; j < 4; j++) begin
        set_fixed(duties[j]);
        wr(0, 1);
        wait_cyc(600);
        measure(512, hi);
        check("R8/R9/R1 fixed duty high count", hi, duties[j]);
      end
    end

    // single-entry window with bit 8 set
    exp_lut[7] = 421;
    wr(8'h80 + 14, 421 & 255);
    wr(8'h81 + 14, 1);
    c_lo = 7; c_hi = 7; c_step = 1; c_phl = 0; c_pll = 0; c_up = 1; c_tog = 0; c_rep = 1;
    load_cfg();
    wr(0, ctrl_word(1, 1));
    wait_cyc(600);
    measure(512, hi);
    check("R1 table duty with bit 8", hi, 421);

    // out-of-range index write is ignored
    c_lo = 2; c_hi = 5; c_up = 0; c_rep = 1;
    load_cfg();
    wr(4, ENTRIES + 8);
    wr(0, ctrl_word(1, 1));
    wait_cyc(2);
    check("R2 rejected high-index write", int'(idx), 5);

    // low above high refuses to start
    c_lo = 9; c_hi = 4;
    load_cfg();
    wr(0, ctrl_word(1, 1));
    wait_cyc(3);
    measure(1100, hi);
    check("R2 refused start keeps pwm low", hi, 0);
    check("R2 refused start done clear", int'(done), 0);

    // duty increase mid-period must not add a pulse
    for (int trial = 0; trial < 4; trial++) begin
      wr(0, 0);
      set_fixed(100);
      wr(0, 1);
      wait_cyc(1200);
      while (pwm == 1'b0) @(negedge clk);
      while (pwm == 1'b1) @(negedge clk);
      wait_cyc(30 + trial * 70);
      wr(2, 1);
      wr(1, 400 & 255);
      rises = 0;
      prev = int'(pwm);
      for (int i = 0; i < 2048; i++) begin
        @(negedge clk);
        if (prev == 0 && pwm == 1'b1) rises++;
        prev = int'(pwm);
      end
      check("R10 one pulse per period", rises, 4);
      measure(512, hi);
      check("R10/R9 new duty applied", hi, 400);
    end

    // disable mid-pattern, then re-enable restarts
    c_lo = 3; c_hi = 8; c_step = 2; c_phl = 0; c_pll = 0;
    c_up = 1; c_tog = 1; c_rep = 1; c_phe = 0; c_ple = 0;
    load_cfg();
    run_pattern(5, "D7");
    wr(0, ctrl_word(0, 1));
    wait_cyc(3);
    check("R11 pwm low after disable", int'(pwm), 0);
    measure(600, hi);
    check("R11 no pulses while disabled", hi, 0);
    check("R11 done clear", int'(done), 0);
    wr(0, ctrl_word(1, 1));
    wait_cyc(2);
    check("R11 restart at starting end", int'(idx), 3);

    // switch to fixed mode while enabled
    set_fixed(200);
    wr(0, ctrl_word(1, 0));
    wait_cyc(600);
    measure(512, hi);
    check("R8 fixed source replaces table", hi, 200);

    // directed stop without repeat
    c_lo = 10; c_hi = 12; c_step = 1; c_phl = 2; c_pll = 0;
    c_up = 1; c_tog = 0; c_rep = 0; c_phe = 1; c_ple = 0;
    load_cfg();
    run_pattern(9, "D9");
    check("R7 stopped done", int'(done), 1);
    wait_cyc(600);
    measure(512, hi);
    check("R7 last duty held", hi, exp_lut[12]);

    // constrained random patterns
    for (int r = 0; r < 14; r++) begin
      c_lo = int'($urandom % ENTRIES);
      c_hi = c_lo + int'($urandom % 6);
      if (c_hi >= ENTRIES) c_hi = ENTRIES - 1;
      c_step = int'($urandom % 4);
      c_phl = int'($urandom % 4);
      c_pll = int'($urandom % 4);
      c_up = int'($urandom % 2);
      c_tog = int'($urandom % 2);
      c_rep = ($urandom % 4 != 0) ? 1 : 0;
      c_phe = int'($urandom % 2);
      c_ple = int'($urandom % 2);
      load_cfg();
      run_pattern(30, "rand");
      wait_cyc(600);
      measure(512, hi);
      check("R9/R1 pattern duty", hi, exp_lut[m_idx]);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule